// File: doc/BRIEF.md
# Display Protection Blanking Controller

This block makes the synchronous decisions that protect a raster display's output stage. It watches two things: a vertical-protection comparator bit, which must fall at least once while vertical blanking is active in every field, and a safety level that an upstream quantizer reduces from a three-level pin to a two-bit code. From these it drives an RGB blank enable and a horizontal drive enable. It also reports the vertical-protection fault and the filtered safety level as status.

The vertical check works per field. A window-scoped "edge seen" flag is cleared when the blanking window opens. The flag is judged when the window closes, and the verdict is applied at the next field-start strobe. It then holds for the whole field that follows.

The safety code is first passed through a flip-flop synchronizer. It is then decoded, and it must stay steady for a set number of samples before it is accepted. The medium level blanks the picture only. The high level blanks the picture and also stops horizontal drive.

Top module: `dpb_blank_ctrl`

## Requirements
- R1: The synchronized safety code is decoded as 00 = low, 01 = medium, 10 or 11 = high. The accepted level is reported on `safety_level` as 00 low, 01 medium, 10 high, and 11 is never reported.
- R2: At the low level the safety path adds no blanking and `hdrive_en` is 1.
- R3: At the medium level `rgb_blank` is 1 and `hdrive_en` is 1.
- R4: At the high level `rgb_blank` is 1 and `hdrive_en` is 0.
- R5: A new decoded level is accepted only after it has been seen in STABLE_CYCLES (default 4) consecutive synchronized samples. A shorter excursion leaves `safety_level` unchanged. A swap between codes 10 and 11 is not a level change.
- R6: A falling edge of `vprot_cmp` counts only in a cycle where `vblank` is 1. A fall outside the window does not count.
- R7: If a blanking window closes with a counted fall, `vp_fault` is 0 after the next `field_start`. If it closes without one, `vp_fault` is 1 after the next `field_start`.
- R8: `vp_fault` changes only at a clock edge where `field_start` is 1. It keeps its value through the rest of the field, including across a window close.
- R9: After reset, `vp_fault` = 1, `rgb_blank` = 1, `hdrive_en` = 0 and `safety_level` = high. This holds until the inputs prove otherwise.
- R10: `rgb_blank` is 1 exactly when `vp_fault` is 1 or the accepted level is not low.
- R11: The edge-seen flag is cleared when a window opens, so a fall counted in one window never satisfies a later window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vprot_cmp | input | 1 | Vertical-protection comparator result, synchronous to clk |
| vblank | input | 1 | Vertical blanking window flag, synchronous to clk |
| field_start | input | 1 | One-cycle strobe at the start of each field |
| safety_code | input | 2 | Quantized safety level, asynchronous |
| rgb_blank | output | 1 | 1 = force RGB outputs to black |
| hdrive_en | output | 1 | 1 = horizontal drive allowed |
| vp_fault | output | 1 | Vertical-protection blank state for the current field |
| safety_level | output | 2 | Accepted safety level (00 low, 01 medium, 10 high) |

## Verification
The vertical check is run over every safety code, each combined with three field patterns: a fall inside the window, no fall at all, and a fall just before the window while the comparator stays low into it. Together these separate a correct window gate from an ungated edge detector and from a flag that is never cleared. Each field is also sampled after the window closes but before the strobe, which shows whether the verdict is held back to the field boundary. The safety filter is swept over every base level, every excursion code and excursion lengths of one to six cycles. This marks exactly where the acceptance threshold lies and confirms that the two high codes are treated as one level.

// File: rtl/dpb_pkg.sv
// Package dpb_pkg
// Shared level encoding for the display protection blanking controller.
// Assumes a two-bit quantized safety code: 00 low, 01 medium, 1x high.
package dpb_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MED  = 2'b01,
        LVL_HIGH = 2'b10
    } lvl_e;

    // Map a raw two-bit code onto the three accepted levels
    function automatic lvl_e decode_level(input logic [1:0] code);
        if (code[1]) begin
            return LVL_HIGH;
        end else if (code[0]) begin
            return LVL_MED;
        end
        return LVL_LOW;
    endfunction

endpackage

// File: rtl/dpb_sync.sv
// Module dpb_sync
// Multi-stage flip-flop synchronizer for a small bus whose bits are
// allowed to be sampled independently (downstream filtering tolerates
// mixed samples). Assumes STAGES >= 1; reset loads RST_VAL into every stage.
module dpb_sync #(
    parameter int unsigned           WIDTH   = 2,
    parameter int unsigned           STAGES  = 2,
    parameter logic [WIDTH-1:0]      RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the asynchronous input
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= d;
            end
        end else begin : g_next
            // Later stages resolve metastability
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/dpb_level_filter.sv
// Module dpb_level_filter
// Accepts a decoded safety level only after it has been sampled in
// STABLE_CYCLES consecutive cycles. Resets to the high (most protective)
// level. Assumes STABLE_CYCLES >= 2 and a synchronized input.
module dpb_level_filter
    import dpb_pkg::*;
#(
    parameter int unsigned STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  lvl_e sample,
    output lvl_e level
);

    localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] CNT_FIRE = CW'(STABLE_CYCLES - 1);
    localparam logic [CW-1:0] CNT_SAT  = CW'(STABLE_CYCLES);

    lvl_e          cand;
    logic [CW-1:0] run_cnt;

    // Track the candidate level and how long it has been seen in a row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand    <= LVL_HIGH;
            run_cnt <= '0;
            level   <= LVL_HIGH;
        end else if (sample != cand) begin
            cand    <= sample;
            run_cnt <= CW'(1);
        end else begin
            if (run_cnt == CNT_FIRE) level <= cand;
            if (run_cnt != CNT_SAT)  run_cnt <= run_cnt + CW'(1);
        end
    end

endmodule

// File: rtl/dpb_vprot_monitor.sv
// Module dpb_vprot_monitor
// Per-field vertical deflection supervision. A falling edge of the
// comparator counts only while vblank is high; the seen flag restarts at
// window open, is judged at window close, and the verdict is applied at
// the next field_start. Assumes all inputs are synchronous to clk.
module dpb_vprot_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic vprot_cmp,
    input  logic vblank,
    input  logic field_start,
    output logic fault
);

    logic cmp_d;
    logic vb_d;
    logic seen;
    logic pending_fail;
    logic fall_in_win;
    logic win_open;
    logic win_close;

    assign fall_in_win = cmp_d & ~vprot_cmp & vblank;
    assign win_open    = vblank & ~vb_d;
    assign win_close   = ~vblank & vb_d;

    // Delay comparator and window flag for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_d <= 1'b0;
            vb_d  <= 1'b0;
        end else begin
            cmp_d <= vprot_cmp;
            vb_d  <= vblank;
        end
    end

    // Window-scoped record of a qualifying falling edge
    always_ff @(posedge clk) begin
        if (!rst_n)           seen <= 1'b0;
        else if (win_open)    seen <= fall_in_win;
        else if (fall_in_win) seen <= 1'b1;
    end

    // Verdict of the most recently closed window
    always_ff @(posedge clk) begin
        if (!rst_n)         pending_fail <= 1'b1;
        else if (win_close) pending_fail <= ~seen;
    end

    // Apply the verdict for a whole field at its start
    always_ff @(posedge clk) begin
        if (!rst_n)           fault <= 1'b1;
        else if (field_start) fault <= pending_fail;
    end

endmodule

// File: rtl/dpb_blank_ctrl.sv
// Module dpb_blank_ctrl
// Top of the display protection blanking controller. Combines the
// per-field vertical protection verdict with the filtered safety level
// into RGB blank and horizontal drive enables. Assumes vprot_cmp, vblank
// and field_start are synchronous; safety_code may be asynchronous.
module dpb_blank_ctrl
    import dpb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned STABLE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vprot_cmp,
    input  logic       vblank,
    input  logic       field_start,
    input  logic [1:0] safety_code,
    output logic       rgb_blank,
    output logic       hdrive_en,
    output logic       vp_fault,
    output logic [1:0] safety_level
);

    logic [1:0] code_sync;
    lvl_e       sync_lvl;
    lvl_e       acc_lvl;

    dpb_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (safety_code),
        .q     (code_sync)
    );

    assign sync_lvl = decode_level(code_sync);

    dpb_level_filter #(
        .STABLE_CYCLES (STABLE_CYCLES)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sync_lvl),
        .level  (acc_lvl)
    );

    dpb_vprot_monitor u_vprot (
        .clk         (clk),
        .rst_n       (rst_n),
        .vprot_cmp   (vprot_cmp),
        .vblank      (vblank),
        .field_start (field_start),
        .fault       (vp_fault)
    );

    // Merge both protection sources into the output enables
    always_comb begin
        rgb_blank    = vp_fault | (acc_lvl != LVL_LOW);
        hdrive_en    = (acc_lvl != LVL_HIGH);
        safety_level = acc_lvl;
    end

endmodule

// File: rtl/dpb_blank_ctrl_chk.sv
// Module dpb_blank_ctrl_chk
// Protocol checker bound to dpb_blank_ctrl. Keeps its own run counter of
// the synchronized level to judge filter acceptance independently.
module dpb_blank_ctrl_chk #(
    parameter int unsigned STABLE_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       field_start,
    input logic [1:0] sync_lvl,
    input logic       rgb_blank,
    input logic       hdrive_en,
    input logic       vp_fault,
    input logic [1:0] safety_level
);

    localparam int unsigned RW = $clog2(STABLE_CYCLES + 1);

    logic [1:0]    last_q;
    logic [RW-1:0] run_q;

    // Count consecutive identical synchronized samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 2'b10;
            run_q  <= '0;
        end else begin
            last_q <= sync_lvl;
            if (sync_lvl != last_q)           run_q <= RW'(1);
            else if (run_q != RW'(STABLE_CYCLES)) run_q <= run_q + RW'(1);
        end
    end

    AST_LEVEL_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
        safety_level != 2'b11);  // R1

    AST_MED_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (safety_level == 2'b01) |-> (rgb_blank && hdrive_en));  // R3

    AST_HIGH_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (safety_level == 2'b10) |-> (rgb_blank && !hdrive_en));  // R4

    AST_LEVEL_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        (safety_level != $past(safety_level)) |->
            (run_q == RW'(STABLE_CYCLES) && safety_level == last_q));  // R5

    AST_VP_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(vp_fault));  // R8

    AST_UNBLANK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !rgb_blank |-> (!vp_fault && safety_level == 2'b00 && hdrive_en));  // R10

endmodule

bind dpb_blank_ctrl dpb_blank_ctrl_chk #(
    .STABLE_CYCLES (STABLE_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .field_start  (field_start),
    .sync_lvl     (sync_lvl),
    .rgb_blank    (rgb_blank),
    .hdrive_en    (hdrive_en),
    .vp_fault     (vp_fault),
    .safety_level (safety_level)
);

// File: tb/test_dpb_blank_ctrl.sv
`timescale 1ns/1ps
module test_dpb_blank_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       vprot_cmp;
    logic       vblank;
    logic       field_start;
    logic [1:0] safety_code;
    logic       rgb_blank;
    logic       hdrive_en;
    logic       vp_fault;
    logic [1:0] safety_level;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    dpb_blank_ctrl i_dpb_blank_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .vprot_cmp    (vprot_cmp),
        .vblank       (vblank),
        .field_start  (field_start),
        .safety_code  (safety_code),
        .rgb_blank    (rgb_blank),
        .hdrive_en    (hdrive_en),
        .vp_fault     (vp_fault),
        .safety_level (safety_level)
    );

    function automatic logic [1:0] exp_level(input logic [1:0] c);
        return c[1] ? 2'b10 : c;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Level monitor for the glitch sweep
    bit         track = 1'b0;
    bit         saw_change;
    logic [1:0] base_exp;
    always @(negedge clk) begin
        if (track && safety_level != base_exp) saw_change = 1'b1;
    end

    // One field: mode 0 no fall, 1 fall inside window, 2 fall just before it
    task automatic do_field(input int mode, input logic [1:0] code, inout bit fault_exp);
        logic [1:0] lvl;
        vprot_cmp = 1'b1;
        cyc(3);
        if (mode == 2) vprot_cmp = 1'b0;   // R6 fall outside window
        cyc(2);
        vblank = 1'b1;
        cyc(2);
        if (mode == 1) vprot_cmp = 1'b0;
        if (mode == 2) vprot_cmp = 1'b1;   // rising only inside
        cyc(2);
        vprot_cmp = 1'b1;
        cyc(2);
        vblank = 1'b0;
        cyc(3);
        chk("R8 hold across window close", vp_fault, fault_exp);
        field_start = 1'b1;
        cyc(1);
        field_start = 1'b0;
        cyc(1);
        fault_exp = (mode != 1);
        lvl = exp_level(code);
        chk(mode == 2 ? "R6 edge outside window" : "R7 field verdict", vp_fault, fault_exp);
        chk("R1 level report", safety_level, lvl);
        chk(lvl == 2'b10 ? "R4 hdrive" : "R2 R3 hdrive", hdrive_en, lvl != 2'b10);
        chk("R10 rgb blank merge", rgb_blank, fault_exp || lvl != 2'b00);
    endtask

    initial begin : main
        bit fault_exp;
        rst_n       = 1'b0;
        vprot_cmp   = 1'b1;
        vblank      = 1'b0;
        field_start = 1'b0;
        safety_code = 2'b00;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R9 reset vp_fault",   vp_fault, 1);
        chk("R9 reset rgb_blank",  rgb_blank, 1);
        chk("R9 reset hdrive_en",  hdrive_en, 0);
        chk("R9 reset level",      safety_level, 2);
        fault_exp = 1'b1;

        // R11: window with edge then window without; verdict must flip back
        for (int c = 0; c < 4; c++) begin
            safety_code = 2'(c);
            cyc(12);
            for (int m = 0; m < 3; m++) begin
                int order [3] = '{1, 0, 2};
                do_field(order[m], 2'(c), fault_exp);
            end
        end
        chk("R11 flag cleared at open", vp_fault, 1);

        // Return to a good vertical state, safety low
        safety_code = 2'b00;
        cyc(12);
        do_field(1, 2'b00, fault_exp);
        chk("R2 low level unblanks", rgb_blank, 0);

        // R5 glitch sweep
        for (int b = 0; b < 3; b++) begin
            for (int p = 0; p < 4; p++) begin
                for (int d = 1; d <= 6; d++) begin
                    logic [1:0] bc;
                    bit expect_change;
                    bc = 2'(b);
                    safety_code = bc;
                    cyc(12);
                    base_exp   = exp_level(bc);
                    saw_change = 1'b0;
                    track      = 1'b1;
                    safety_code = 2'(p);
                    cyc(d);
                    safety_code = bc;
                    cyc(14);
                    track = 1'b0;
                    expect_change = (d >= 4) && (exp_level(2'(p)) != base_exp);
                    chk("R5 glitch filter", saw_change, expect_change);
                    chk("R5 final level", safety_level, base_exp);
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule